// File: doc/BRIEF.md
# CAN Status and Bus-Off Controller

This block holds the status fields of a CAN controller and the bus-off recovery sequence. The protocol engine feeds it single-cycle event strobes for a good transmit, a good receive and a last-error code, plus the live transmit and receive error counter values. A per-bit-time strobe carries the sampled bus level. The CPU writes the status fields and a small control word (INIT, IE, SIE, EIE). The block returns the status fields, the INIT bit, a status-change interrupt pulse, an error interrupt pulse, and a strobe that tells the engine to clear its error counters.

TxOk and RxOk are sticky. The core only sets them and the CPU only clears them. The error code field accepts a CPU-written 7 as a marker that shows whether any bus event has arrived since. When the transmit error counter passes 255, the block enters bus-off and forces INIT high. The CPU starts recovery by clearing INIT. Recovery then counts groups of 11 consecutive recessive bits, and no INIT write can shorten or restart it. After 128 such groups, bus-off ends and the counter-clear strobe fires.

Top module: `can_status_ctrl`

## Requirements
- R1: After reset, INIT reads 1 and the error code, TxOk, RxOk, EWarn, EPass, BOff, both interrupt pulses and the counter-clear strobe read 0.
- R2: An error-code strobe with a code from 0 to 6 (0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC) loads that code into the error-code field at the next edge. A strobe carrying code 7 is ignored.
- R3: A CPU status write loads the error code, TxOk and RxOk from the write data. A written code of 7 stays in place until the next hardware update of the field.
- R4: TxOk and RxOk are set by their event strobes and cleared only by a CPU write. If an event and a CPU clear arrive in the same cycle, the event wins.
- R5: EWarn reads 1 when either error counter was at or above 96 at the previous edge. EPass reads 1 when either counter was at or above 128 at the previous edge. Both are read-only.
- R6: When IE and SIE are both set, status_irq is high for one cycle after every edge that applies a hardware update of TxOk, RxOk or the error code. Otherwise status_irq stays low.
- R7: When IE and EIE are both set, error_irq is high in every cycle where EWarn or BOff shows a value different from the cycle before. Otherwise error_irq stays low.
- R8: When the transmit error counter exceeds 255, BOff is set and INIT is forced to 1 on the same edge.
- R9: Recovery starts only when the CPU writes INIT to 0 while BOff is set. Bit strobes before that have no effect on the error code or on BOff.
- R10: During recovery, every run of 11 consecutive recessive bit strobes writes 5 to the error code, which counts as a hardware update for R6. A dominant bit strobe restarts the current run but keeps the number of completed runs.
- R11: CPU writes to INIT during recovery are ignored: INIT stays 0 and the run count is not disturbed.
- R12: At the end of the 128th run, BOff clears, INIT stays 0, and err_cnt_reset is high for exactly the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_ok | input | 1 | Successful transmit strobe |
| ev_rx_ok | input | 1 | Successful receive strobe |
| ev_lec_vld | input | 1 | Error-code strobe |
| ev_lec | input | 3 | Error code carried with the strobe |
| tec | input | CNT_W | Transmit error counter value |
| rec | input | CNT_W | Receive error counter value |
| bit_tick | input | 1 | One pulse per bit time |
| bit_recessive | input | 1 | Sampled bus level is recessive, valid with bit_tick |
| cpu_st_wr | input | 1 | CPU write to the status fields |
| cpu_st_lec | input | 3 | Error code write data |
| cpu_st_txok | input | 1 | TxOk write data |
| cpu_st_rxok | input | 1 | RxOk write data |
| cpu_ctl_wr | input | 1 | CPU write to the control word |
| cpu_ctl_init | input | 1 | INIT write data |
| cpu_ctl_ie | input | 1 | Interrupt enable write data |
| cpu_ctl_sie | input | 1 | Status interrupt enable write data |
| cpu_ctl_eie | input | 1 | Error interrupt enable write data |
| st_lec | output | 3 | Last error code field |
| st_txok | output | 1 | Sticky transmit-OK flag |
| st_rxok | output | 1 | Sticky receive-OK flag |
| st_epass | output | 1 | Error-passive level |
| st_ewarn | output | 1 | Error-warning level |
| st_boff | output | 1 | Bus-off state |
| ctl_init | output | 1 | INIT control bit |
| status_irq | output | 1 | Status-change interrupt pulse |
| error_irq | output | 1 | Error interrupt pulse |
| err_cnt_reset | output | 1 | Request to the engine to clear its error counters |

## Verification
The properties assume that the protocol engine never issues error-code strobes while the block is in bus-off. They also assume the engine answers err_cnt_reset by bringing the transmit counter back to 255 or below before the cycle after the strobe. The stimulus keeps every event strobe at zero during the bus-off phase and clears the transmit counter on the sample right after the strobe appears. The counter sweeps move in single steps, except for one deliberate jump that checks the falling edge of EWarn.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  typedef enum logic [2:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_UNSET = 3'd7
  } lec_e;
endpackage

// File: rtl/can_err_level.sv
module can_err_level #(
  parameter int CNT_W       = 9,
  parameter int WARN_LIMIT  = 96,
  parameter int PASS_LIMIT  = 128,
  parameter int BOFF_LIMIT  = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  output logic             ewarn,
  output logic             epass,
  output logic             boff_hit
);
  localparam logic [CNT_W-1:0] WarnLim = CNT_W'(WARN_LIMIT);
  localparam logic [CNT_W-1:0] PassLim = CNT_W'(PASS_LIMIT);
  localparam logic [CNT_W-1:0] BoffLim = CNT_W'(BOFF_LIMIT);

  logic ewarn_q, ewarn_d, epass_q, epass_d;

  always_comb begin
    ewarn_d  = (tec >= WarnLim) || (rec >= WarnLim);
    epass_d  = (tec >= PassLim) || (rec >= PassLim);
    boff_hit = (tec > BoffLim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ewarn_q <= 1'b0;
      epass_q <= 1'b0;
    end else begin
      ewarn_q <= ewarn_d;
      epass_q <= epass_d;
    end
  end

  assign ewarn = ewarn_q;
  assign epass = epass_q;
endmodule

// File: rtl/can_status_reg.sv
module can_status_reg
  import can_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_tx_ok,
  input  logic       ev_rx_ok,
  input  logic       ev_lec_vld,
  input  logic [2:0] ev_lec,
  input  logic       run_done,
  input  logic       cpu_wr,
  input  logic [2:0] cpu_lec,
  input  logic       cpu_txok,
  input  logic       cpu_rxok,
  output logic [2:0] lec,
  output logic       txok,
  output logic       rxok,
  output logic       hw_update
);
  lec_e lec_q, lec_d;
  logic txok_q, txok_d, rxok_q, rxok_d;
  logic hw_lec_ok;

  always_comb begin
    hw_lec_ok = ev_lec_vld && (lec_e'(ev_lec) != LEC_UNSET);
    lec_d  = lec_q;
    txok_d = txok_q;
    rxok_d = rxok_q;
    // CPU first, core events override in the same cycle
    if (cpu_wr) begin
      lec_d  = lec_e'(cpu_lec);
      txok_d = cpu_txok;
      rxok_d = cpu_rxok;
    end
    if (hw_lec_ok) lec_d = lec_e'(ev_lec);
    if (run_done)  lec_d = LEC_BIT0;
    if (ev_tx_ok)  txok_d = 1'b1;
    if (ev_rx_ok)  rxok_d = 1'b1;
    hw_update = hw_lec_ok || run_done || ev_tx_ok || ev_rx_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lec_q  <= LEC_NONE;
      txok_q <= 1'b0;
      rxok_q <= 1'b0;
    end else begin
      lec_q  <= lec_d;
      txok_q <= txok_d;
      rxok_q <= rxok_d;
    end
  end

  assign lec  = lec_q;
  assign txok = txok_q;
  assign rxok = rxok_q;
endmodule

// File: rtl/can_busoff_seq.sv
module can_busoff_seq #(
  parameter int RUN_LEN     = 11,
  parameter int RUNS_NEEDED = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boff_hit,
  input  logic ctl_wr,
  input  logic ctl_init_wd,
  input  logic bit_tick,
  input  logic bit_recessive,
  output logic boff,
  output logic init,
  output logic run_done,
  output logic cnt_rst
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int GRP_W = $clog2(RUNS_NEEDED);
  localparam logic [RUN_W-1:0] RunLast = RUN_W'(RUN_LEN - 1);
  localparam logic [GRP_W-1:0] GrpLast = GRP_W'(RUNS_NEEDED - 1);

  logic             boff_q, boff_d, init_q, init_d;
  logic             act_q, act_d, rst_q, rst_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic             entry;

  always_comb begin
    boff_d   = boff_q;
    init_d   = init_q;
    act_d    = act_q;
    run_d    = run_q;
    grp_d    = grp_q;
    rst_d    = 1'b0;
    run_done = 1'b0;
    entry    = boff_hit && !boff_q && !rst_q;
    if (entry) begin
      boff_d = 1'b1;
      init_d = 1'b1;
      act_d  = 1'b0;
      run_d  = '0;
      grp_d  = '0;
    end else if (act_q) begin
      // recovery in progress: CPU INIT writes have no effect
      if (bit_tick) begin
        if (!bit_recessive) begin
          run_d = '0;
        end else if (run_q == RunLast) begin
          run_d    = '0;
          run_done = 1'b1;
          if (grp_q == GrpLast) begin
            boff_d = 1'b0;
            act_d  = 1'b0;
            grp_d  = '0;
            rst_d  = 1'b1;
          end else begin
            grp_d = grp_q + 1'b1;
          end
        end else begin
          run_d = run_q + 1'b1;
        end
      end
    end else if (ctl_wr) begin
      init_d = ctl_init_wd;
      if (boff_q && !ctl_init_wd) begin
        act_d = 1'b1;
        run_d = '0;
        grp_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boff_q <= 1'b0;
      init_q <= 1'b1;
      act_q  <= 1'b0;
      run_q  <= '0;
      grp_q  <= '0;
      rst_q  <= 1'b0;
    end else begin
      boff_q <= boff_d;
      init_q <= init_d;
      act_q  <= act_d;
      run_q  <= run_d;
      grp_q  <= grp_d;
      rst_q  <= rst_d;
    end
  end

  assign boff    = boff_q;
  assign init    = init_q;
  assign cnt_rst = rst_q;
endmodule

// File: rtl/can_status_ctrl.sv
module can_status_ctrl #(
  parameter int CNT_W       = 9,
  parameter int WARN_LIMIT  = 96,
  parameter int PASS_LIMIT  = 128,
  parameter int BOFF_LIMIT  = 255,
  parameter int RUN_LEN     = 11,
  parameter int RUNS_NEEDED = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_tx_ok,
  input  logic             ev_rx_ok,
  input  logic             ev_lec_vld,
  input  logic [2:0]       ev_lec,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  input  logic             bit_tick,
  input  logic             bit_recessive,
  input  logic             cpu_st_wr,
  input  logic [2:0]       cpu_st_lec,
  input  logic             cpu_st_txok,
  input  logic             cpu_st_rxok,
  input  logic             cpu_ctl_wr,
  input  logic             cpu_ctl_init,
  input  logic             cpu_ctl_ie,
  input  logic             cpu_ctl_sie,
  input  logic             cpu_ctl_eie,
  output logic [2:0]       st_lec,
  output logic             st_txok,
  output logic             st_rxok,
  output logic             st_epass,
  output logic             st_ewarn,
  output logic             st_boff,
  output logic             ctl_init,
  output logic             status_irq,
  output logic             error_irq,
  output logic             err_cnt_reset
);
  logic boff_hit, run_done, hw_update;
  logic ie_q, sie_q, eie_q;
  logic sirq_q, sirq_d;
  logic ewarn_prev_q, boff_prev_q;

  can_err_level #(
    .CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT),
    .PASS_LIMIT(PASS_LIMIT), .BOFF_LIMIT(BOFF_LIMIT)
  ) u_level (
    .clk(clk), .rst_n(rst_n), .tec(tec), .rec(rec),
    .ewarn(st_ewarn), .epass(st_epass), .boff_hit(boff_hit)
  );

  can_busoff_seq #(.RUN_LEN(RUN_LEN), .RUNS_NEEDED(RUNS_NEEDED)) u_seq (
    .clk(clk), .rst_n(rst_n), .boff_hit(boff_hit),
    .ctl_wr(cpu_ctl_wr), .ctl_init_wd(cpu_ctl_init),
    .bit_tick(bit_tick), .bit_recessive(bit_recessive),
    .boff(st_boff), .init(ctl_init), .run_done(run_done),
    .cnt_rst(err_cnt_reset)
  );

  can_status_reg u_stat (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
    .ev_lec_vld(ev_lec_vld), .ev_lec(ev_lec), .run_done(run_done),
    .cpu_wr(cpu_st_wr), .cpu_lec(cpu_st_lec),
    .cpu_txok(cpu_st_txok), .cpu_rxok(cpu_st_rxok),
    .lec(st_lec), .txok(st_txok), .rxok(st_rxok), .hw_update(hw_update)
  );

  always_comb sirq_d = ie_q && sie_q && hw_update;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      sie_q <= 1'b0;
      eie_q <= 1'b0;
    end else if (cpu_ctl_wr) begin
      ie_q  <= cpu_ctl_ie;
      sie_q <= cpu_ctl_sie;
      eie_q <= cpu_ctl_eie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sirq_q       <= 1'b0;
      ewarn_prev_q <= 1'b0;
      boff_prev_q  <= 1'b0;
    end else begin
      sirq_q       <= sirq_d;
      ewarn_prev_q <= st_ewarn;
      boff_prev_q  <= st_boff;
    end
  end

  assign status_irq = sirq_q;
  assign error_irq  = ie_q && eie_q &&
                      ((st_ewarn ^ ewarn_prev_q) || (st_boff ^ boff_prev_q));
endmodule

// File: rtl/can_status_ctrl_chk.sv
module can_status_ctrl_chk #(
  parameter int CNT_W      = 9,
  parameter int WARN_LIMIT = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_lec_vld,
  input logic [2:0]       ev_lec,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic             cpu_st_wr,
  input logic [2:0]       st_lec,
  input logic             st_txok,
  input logic             st_rxok,
  input logic             st_ewarn,
  input logic             st_boff,
  input logic             ctl_init,
  input logic             error_irq,
  input logic             err_cnt_reset
);
  localparam logic [CNT_W-1:0] WarnLim = CNT_W'(WARN_LIMIT);

  p_lec_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lec_vld && ev_lec != 3'd7 && !st_boff) |=> (st_lec == $past(ev_lec)));

  p_txok_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_txok && !cpu_st_wr) |=> st_txok);

  p_rxok_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rxok && !cpu_st_wr) |=> st_rxok);

  p_ewarn_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (st_ewarn == (($past(tec) >= WarnLim) || ($past(rec) >= WarnLim))));

  p_err_irq_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error_irq |-> ((st_ewarn != $past(st_ewarn)) || (st_boff != $past(st_boff))));

  p_boff_forces_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_boff) |-> ctl_init);

  p_init_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_boff && !ctl_init) |=> !ctl_init);

  p_cnt_rst_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt_reset |-> $fell(st_boff));
endmodule

bind can_status_ctrl can_status_ctrl_chk #(.CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_lec_vld(ev_lec_vld), .ev_lec(ev_lec),
  .tec(tec), .rec(rec), .cpu_st_wr(cpu_st_wr), .st_lec(st_lec),
  .st_txok(st_txok), .st_rxok(st_rxok), .st_ewarn(st_ewarn),
  .st_boff(st_boff), .ctl_init(ctl_init), .error_irq(error_irq),
  .err_cnt_reset(err_cnt_reset)
);

// File: tb/can_status_ctrl_test.sv
module can_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_tx_ok, ev_rx_ok, ev_lec_vld;
  logic [2:0] ev_lec;
  logic [CNT_W-1:0] tec, rec;
  logic bit_tick, bit_recessive;
  logic cpu_st_wr, cpu_st_txok, cpu_st_rxok;
  logic [2:0] cpu_st_lec;
  logic cpu_ctl_wr, cpu_ctl_init, cpu_ctl_ie, cpu_ctl_sie, cpu_ctl_eie;
  logic [2:0] st_lec;
  logic st_txok, st_rxok, st_epass, st_ewarn, st_boff, ctl_init;
  logic status_irq, error_irq, err_cnt_reset;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_status_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
    .ev_lec_vld(ev_lec_vld), .ev_lec(ev_lec),
    .tec(tec), .rec(rec),
    .bit_tick(bit_tick), .bit_recessive(bit_recessive),
    .cpu_st_wr(cpu_st_wr), .cpu_st_lec(cpu_st_lec),
    .cpu_st_txok(cpu_st_txok), .cpu_st_rxok(cpu_st_rxok),
    .cpu_ctl_wr(cpu_ctl_wr), .cpu_ctl_init(cpu_ctl_init),
    .cpu_ctl_ie(cpu_ctl_ie), .cpu_ctl_sie(cpu_ctl_sie), .cpu_ctl_eie(cpu_ctl_eie),
    .st_lec(st_lec), .st_txok(st_txok), .st_rxok(st_rxok),
    .st_epass(st_epass), .st_ewarn(st_ewarn), .st_boff(st_boff),
    .ctl_init(ctl_init), .status_irq(status_irq), .error_irq(error_irq),
    .err_cnt_reset(err_cnt_reset)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic ctl_write(input logic init, input logic ie, input logic sie, input logic eie);
    cpu_ctl_wr = 1'b1; cpu_ctl_init = init;
    cpu_ctl_ie = ie; cpu_ctl_sie = sie; cpu_ctl_eie = eie;
    step();
    cpu_ctl_wr = 1'b0;
  endtask

  task automatic st_write(input logic [2:0] lec, input logic tx, input logic rx);
    cpu_st_wr = 1'b1; cpu_st_lec = lec; cpu_st_txok = tx; cpu_st_rxok = rx;
    step();
    cpu_st_wr = 1'b0;
  endtask

  task automatic tick(input logic recessive);
    bit_tick = 1'b1; bit_recessive = recessive;
    step();
    bit_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic exp_w, exp_p, prev_w;
    rst_n = 1'b0;
    ev_tx_ok = 0; ev_rx_ok = 0; ev_lec_vld = 0; ev_lec = 0;
    tec = 0; rec = 0; bit_tick = 0; bit_recessive = 0;
    cpu_st_wr = 0; cpu_st_lec = 0; cpu_st_txok = 0; cpu_st_rxok = 0;
    cpu_ctl_wr = 0; cpu_ctl_init = 0; cpu_ctl_ie = 0; cpu_ctl_sie = 0; cpu_ctl_eie = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 init", ctl_init, 1);
    chk("R1 lec", st_lec, 0);
    chk("R1 flags", {st_txok, st_rxok, st_epass, st_ewarn, st_boff}, 0);
    chk("R1 pulses", {status_irq, error_irq, err_cnt_reset}, 0);
    rst_n = 1'b1;
    step();
    ctl_write(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R9 init write outside bus-off", ctl_init, 0);

    // R2 / R6 sweep of all hardware codes
    for (int c = 0; c < 8; c++) begin
      ev_lec_vld = 1'b1; ev_lec = 3'(c);
      step();
      ev_lec_vld = 1'b0;
      chk("R2 lec load", st_lec, (c == 7) ? 6 : c);
      chk("R6 irq on lec update", status_irq, (c == 7) ? 0 : 1);
    end

    // R3 sentinel 7
    st_write(3'd7, 1'b0, 1'b0);
    chk("R3 sentinel written", st_lec, 7);
    chk("R6 cpu write no irq", status_irq, 0);
    repeat (5) step();
    chk("R3 sentinel held", st_lec, 7);
    ev_lec_vld = 1'b1; ev_lec = 3'd0;
    step();
    ev_lec_vld = 1'b0;
    chk("R3 sentinel replaced", st_lec, 0);

    // R4 sticky flags
    ev_tx_ok = 1'b1; step(); ev_tx_ok = 1'b0;
    chk("R4 txok set", st_txok, 1);
    chk("R6 irq on txok", status_irq, 1);
    repeat (4) step();
    chk("R4 txok held", st_txok, 1);
    chk("R6 irq single cycle", status_irq, 0);
    st_write(3'd0, 1'b0, 1'b0);
    chk("R4 txok cleared by cpu", st_txok, 0);
    ev_rx_ok = 1'b1; step(); ev_rx_ok = 1'b0;
    chk("R4 rxok set", st_rxok, 1);
    repeat (3) step();
    chk("R4 rxok held", st_rxok, 1);
    cpu_st_wr = 1'b1; cpu_st_lec = 0; cpu_st_txok = 0; cpu_st_rxok = 0;
    ev_tx_ok = 1'b1;
    step();
    cpu_st_wr = 1'b0; ev_tx_ok = 1'b0;
    chk("R4 event beats cpu clear", st_txok, 1);
    chk("R4 rxok cleared", st_rxok, 0);

    // R6 gating
    ctl_write(1'b0, 1'b1, 1'b0, 1'b1);
    ev_rx_ok = 1'b1; step(); ev_rx_ok = 1'b0;
    chk("R6 sie off no irq", status_irq, 0);
    ctl_write(1'b0, 1'b0, 1'b1, 1'b1);
    ev_tx_ok = 1'b1; step(); ev_tx_ok = 1'b0;
    chk("R6 ie off no irq", status_irq, 0);
    ctl_write(1'b0, 1'b1, 1'b1, 1'b1);

    // R5 / R7 transmit counter sweep
    prev_w = 1'b0;
    for (int v = 0; v < 256; v++) begin
      tec = CNT_W'(v);
      step();
      exp_w = (v >= 96);
      exp_p = (v >= 128);
      chk("R5 ewarn tec", st_ewarn, exp_w);
      chk("R5 epass tec", st_epass, exp_p);
      chk("R7 error irq tec", error_irq, exp_w != prev_w);
      prev_w = exp_w;
    end
    tec = 0;
    step();
    chk("R5 ewarn falls", st_ewarn, 0);
    chk("R7 irq on fall", error_irq, 1);
    // receive counter sweep with EIE off
    ctl_write(1'b0, 1'b1, 1'b1, 1'b0);
    for (int v = 0; v < 300; v++) begin
      rec = CNT_W'(v);
      step();
      chk("R5 ewarn rec", st_ewarn, (v >= 96));
      chk("R5 epass rec", st_epass, (v >= 128));
      chk("R7 eie off", error_irq, 0);
    end
    rec = 0;
    step();
    ctl_write(1'b0, 1'b1, 1'b1, 1'b1);

    // R8 bus-off entry
    st_write(3'd7, 1'b0, 1'b0);
    tec = 9'd256;
    step();
    chk("R8 boff", st_boff, 1);
    chk("R8 init forced", ctl_init, 1);
    chk("R7 irq on boff", error_irq, 1);
    step();
    chk("R7 irq single", error_irq, 0);

    // R9 ticks before recovery start ignored
    for (int i = 0; i < 30; i++) tick(1'b1);
    chk("R9 no lec before start", st_lec, 7);
    chk("R9 boff held", st_boff, 1);
    ctl_write(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R9 init cleared", ctl_init, 0);

    // R10 dominant restarts current run
    for (int i = 0; i < 10; i++) tick(1'b1);
    tick(1'b0);
    for (int i = 0; i < 10; i++) tick(1'b1);
    chk("R10 dominant restart", st_lec, 7);
    tick(1'b1);
    chk("R10 run writes bit0", st_lec, 5);
    chk("R10 run irq", status_irq, 1);

    // R11 INIT writes during recovery ignored
    ctl_write(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R11 init stays 0", ctl_init, 0);
    chk("R11 boff stays", st_boff, 1);
    ctl_write(1'b0, 1'b1, 1'b1, 1'b1);

    // R12 remaining runs: 126 full, then the last one
    for (int r = 0; r < 126; r++) begin
      for (int i = 0; i < 11; i++) tick(1'b1);
    end
    chk("R12 not early", st_boff, 1);
    for (int i = 0; i < 10; i++) tick(1'b1);
    chk("R12 not before last bit", st_boff, 1);
    chk("R12 no reset yet", err_cnt_reset, 0);
    tick(1'b1);
    chk("R12 boff clears", st_boff, 0);
    chk("R12 counter reset", err_cnt_reset, 1);
    chk("R12 init stays 0", ctl_init, 0);
    chk("R10 last run lec", st_lec, 5);
    tec = 0;
    step();
    chk("R12 reset single cycle", err_cnt_reset, 0);
    chk("R12 stays out of bus-off", st_boff, 0);

    report();
  end
endmodule